// File: doc/BRIEF.md
# Interrupt Priority and Acceptance Unit

This unit sits beside one processor and decides which pending interrupt vector that processor may take. It tracks three 256-bit vector sets: requests waiting for service, vectors currently being serviced, and the trigger type of each vector (level or edge). A task-priority value written by software, together with the class of the highest vector in service, forms the processor priority. A request is offered only when its class is above that priority. Class means the upper four bits of the eight-bit vector number.

The processor reads a vector with a one-cycle request/answer handshake. A deliverable vector moves from the request set to the in-service set. A request that exists but is held back by priority returns a programmable spurious vector. An end-of-interrupt strobe retires the highest vector in service. When that vector was level-triggered and directed end-of-interrupt is off, the unit emits a broadcast carrying the vector so that upstream routers can re-arm the line. A spurious-vector register also holds the software enable bit, which gates all delivery.

Top module: `vpu_accept_unit`

## Requirements
- R1: After a synchronous active-low reset, the task priority and the request, in-service and trigger sets are all clear. The spurious vector is 0xFF, software enable is off and directed end-of-interrupt is off, so `ppr_out` is 0 and `irq_pending` is 0.
- R2: A `req_valid` cycle sets the request bit of `req_vector` and overwrites its trigger bit: 1 when `req_level` is high, 0 otherwise. A later request for the same vector replaces its trigger type.
- R3: Among pending requests the highest vector number is served first. Among in-service vectors the highest number defines the in-service class and is the one retired by end-of-interrupt.
- R4: `ppr_out` equals the task priority when the task-priority class (bits 7:4) is at least the in-service class, and otherwise equals the in-service class shifted left by 4. An empty in-service set counts as class 0.
- R5: A request is deliverable when `ppr_out` is 0 or the class of the highest request is strictly greater than `ppr_out[7:4]`. `irq_pending` is high exactly when a request is deliverable and software enable is on. Both outputs follow the registered state with no added delay.
- R6: An acknowledge with a deliverable request returns that vector with `ack_vld` high in the cycle after `ack_req`. The same edge clears its request bit and sets its in-service bit.
- R7: An acknowledge while requests exist but none is deliverable returns the spurious vector (SVR bits 7:0) with `ack_vld` high and changes no state.
- R8: An acknowledge with no pending request raises `ack_done` with `ack_vld` low.
- R9: `eoi_strobe` clears the highest in-service bit. If that vector's trigger bit is 1 and directed end-of-interrupt is off, `eoi_bc_valid` pulses with `eoi_bc_vector` equal to the vector in the next cycle. Otherwise no broadcast is made.
- R10: `eoi_strobe` with an empty in-service set changes nothing and makes no broadcast.
- R11: An `svr_we` write keeps `svr_wdata` bits 7:0 as the spurious vector, bit 8 as software enable and bit 12 as directed end-of-interrupt. While software enable is off, `irq_pending` stays low and an acknowledge returns no vector.
- R12: `ack_done` is high exactly in the cycle after each `ack_req` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Raise a request for `req_vector` |
| req_vector | input | 8 | Vector being requested |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | Processor asks for a vector |
| ack_done | output | 1 | Answer to the previous `ack_req` |
| ack_vld | output | 1 | A vector is returned with `ack_done` |
| ack_vector | output | 8 | Returned vector (serviced or spurious) |
| eoi_strobe | input | 1 | End of interrupt for the highest in-service vector |
| eoi_bc_valid | output | 1 | End-of-interrupt broadcast pulse |
| eoi_bc_vector | output | 8 | Vector carried by the broadcast |
| tpr_we | input | 1 | Write the task priority |
| tpr_wdata | input | 8 | Task priority value |
| svr_we | input | 1 | Write the spurious-vector register |
| svr_wdata | input | 16 | Bits 7:0 vector, bit 8 enable, bit 12 directed end-of-interrupt |
| ppr_out | output | 8 | Current processor priority |
| irq_pending | output | 1 | A deliverable request is waiting |

## Verification
The bound checker watches the handshake shape on every cycle: `ack_done` follows each `ack_req` and nothing else, and a returned vector only comes with `ack_done`. It also checks that no vector or pending flag appears while enable is off, that the processor priority never falls below the task priority and equals it when nothing is in service, and that broadcasts only follow an end-of-interrupt with work to retire. Which vector is chosen, the spurious answer under blocking, the conditions for a broadcast, and how trigger types are overwritten depend on a history of requests and acknowledges. Only the bench's sequenced scenarios can show those, along with the clearing effect of a reset taken mid-service.

// File: rtl/vpu_pkg.sv
// Package: shared widths and helpers for the vector priority unit.
// Assumes 8-bit vectors whose upper nibble is the priority class.
package vpu_pkg;
    localparam int VEC_W = 8;
    localparam int CLS_W = 4;
    localparam int SVR_W = 16;
    localparam int SVR_EN_BIT  = 8;
    localparam int SVR_DIR_BIT = 12;

    // Priority class of a vector (upper nibble).
    function automatic logic [CLS_W-1:0] prio_class(input logic [VEC_W-1:0] v);
        return v[VEC_W-1 -: CLS_W];
    endfunction
endpackage

// File: rtl/vpu_grp_enc.sv
// Module: vpu_grp_enc
// Finds the highest set bit of one group of the vector set.
// Purely combinational; the caller registers the result.
module vpu_grp_enc #(
    parameter int GRP_W = 32,
    localparam int IDX_W = $clog2(GRP_W)
) (
    input  logic [GRP_W-1:0] bits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Ascending scan so the highest set bit is the last one kept.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < GRP_W; i++) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vpu_hi_find.sv
// Module: vpu_hi_find
// Two-level highest-set-bit search over a vector set. Level one encodes each
// group from the next-state value and registers it, so after the edge that
// updates the set the result already matches it. Level two selects the highest
// non-empty group combinationally. Assumes at least two groups.
module vpu_hi_find #(
    parameter int NUM_VEC = 256,
    parameter int GRP_W   = 32,
    localparam int NUM_GRP = NUM_VEC / GRP_W,
    localparam int IDX_W   = $clog2(GRP_W),
    localparam int GSEL_W  = $clog2(NUM_GRP),
    localparam int VW      = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] vec_nxt,
    output logic               any,
    output logic [VW-1:0]      top
);
    logic [NUM_GRP-1:0] g_any_c, g_any_q;
    logic [IDX_W-1:0]   g_idx_c [NUM_GRP];
    logic [IDX_W-1:0]   g_idx_q [NUM_GRP];

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        vpu_grp_enc #(.GRP_W(GRP_W)) u_enc (
            .bits (vec_nxt[g*GRP_W +: GRP_W]),
            .any  (g_any_c[g]),
            .idx  (g_idx_c[g])
        );

        // Register this group's summary alongside the set itself.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                g_any_q[g] <= 1'b0;
                g_idx_q[g] <= '0;
            end else begin
                g_any_q[g] <= g_any_c[g];
                g_idx_q[g] <= g_idx_c[g];
            end
        end
    end

    // Pick the highest non-empty group and join its index.
    always_comb begin
        any = 1'b0;
        top = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (g_any_q[g]) begin
                any = 1'b1;
                top = {GSEL_W'(g), g_idx_q[g]};
            end
        end
    end
endmodule

// File: rtl/vpu_prio_calc.sv
// Module: vpu_prio_calc
// Forms the processor priority from the task priority and the top in-service
// vector, and decides whether the top request may be delivered.
module vpu_prio_calc
    import vpu_pkg::*;
(
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_any,
    input  logic [VEC_W-1:0] isr_top,
    input  logic             irr_any,
    input  logic [VEC_W-1:0] irr_top,
    output logic [VEC_W-1:0] ppr,
    output logic             deliverable
);
    logic [CLS_W-1:0] isr_cls;

    // Processor priority: the larger of task class and in-service class.
    always_comb begin
        isr_cls = isr_any ? prio_class(isr_top) : '0;
        if (prio_class(tpr) >= isr_cls) ppr = tpr;
        else                            ppr = {isr_cls, {(VEC_W-CLS_W){1'b0}}};
    end

    // Top request passes when priority is zero or its class is strictly above.
    always_comb begin
        deliverable = irr_any &&
                      ((ppr == '0) || (prio_class(irr_top) > prio_class(ppr)));
    end
endmodule

// File: rtl/vpu_accept_unit.sv
// Module: vpu_accept_unit (top)
// Holds request, in-service and trigger sets for one processor, answers
// acknowledges with a serviced or spurious vector, retires vectors on
// end-of-interrupt and broadcasts level-triggered retirements.
// Assumes at most one request, acknowledge and EOI per cycle each; a request
// arriving in the same cycle as the acknowledge of that vector leaves its
// request bit set.
module vpu_accept_unit
    import vpu_pkg::*;
#(
    parameter int GRP_W = 32,
    localparam int NUM_VEC = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vector,
    input  logic             req_level,
    input  logic             ack_req,
    output logic             ack_done,
    output logic             ack_vld,
    output logic [VEC_W-1:0] ack_vector,
    input  logic             eoi_strobe,
    output logic             eoi_bc_valid,
    output logic [VEC_W-1:0] eoi_bc_vector,
    input  logic             tpr_we,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             svr_we,
    input  logic [SVR_W-1:0] svr_wdata,
    output logic [VEC_W-1:0] ppr_out,
    output logic             irq_pending
);
    localparam logic [NUM_VEC-1:0] ONE = {{(NUM_VEC-1){1'b0}}, 1'b1};

    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q, irr_nxt, isr_nxt;
    logic [NUM_VEC-1:0] set_m, take_m, eoi_m;
    logic [VEC_W-1:0]   tpr_q, sv_vec_q;
    logic               sv_en_q, sv_dir_q;
    logic               irr_any, isr_any, deliverable, ack_take, eoi_take;
    logic [VEC_W-1:0]   irr_top, isr_top;

    // Highest request and highest in-service vector.
    vpu_hi_find #(.NUM_VEC(NUM_VEC), .GRP_W(GRP_W)) u_irr_find (
        .clk(clk), .rst_n(rst_n), .vec_nxt(irr_nxt), .any(irr_any), .top(irr_top)
    );
    vpu_hi_find #(.NUM_VEC(NUM_VEC), .GRP_W(GRP_W)) u_isr_find (
        .clk(clk), .rst_n(rst_n), .vec_nxt(isr_nxt), .any(isr_any), .top(isr_top)
    );

    vpu_prio_calc u_prio (
        .tpr(tpr_q), .isr_any(isr_any), .isr_top(isr_top),
        .irr_any(irr_any), .irr_top(irr_top),
        .ppr(ppr_out), .deliverable(deliverable)
    );

    // Decide which bits move this cycle.
    always_comb begin
        ack_take = ack_req && sv_en_q && deliverable;
        eoi_take = eoi_strobe && isr_any;
        set_m    = req_valid ? (ONE << req_vector) : '0;
        take_m   = ack_take  ? (ONE << irr_top)    : '0;
        eoi_m    = eoi_take  ? (ONE << isr_top)    : '0;
        irr_nxt  = (irr_q & ~take_m) | set_m;
        isr_nxt  = (isr_q & ~eoi_m)  | take_m;
    end

    // Vector-set state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
        end else begin
            irr_q <= irr_nxt;
            isr_q <= isr_nxt;
            if (req_valid) tmr_q[req_vector] <= req_level;
        end
    end

    // Task priority and spurious-vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q    <= '0;
            sv_vec_q <= '1;
            sv_en_q  <= 1'b0;
            sv_dir_q <= 1'b0;
        end else begin
            if (tpr_we) tpr_q <= tpr_wdata;
            if (svr_we) begin
                sv_vec_q <= svr_wdata[VEC_W-1:0];
                sv_en_q  <= svr_wdata[SVR_EN_BIT];
                sv_dir_q <= svr_wdata[SVR_DIR_BIT];
            end
        end
    end

    // Acknowledge answer, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_done   <= 1'b0;
            ack_vld    <= 1'b0;
            ack_vector <= '0;
        end else begin
            ack_done   <= ack_req;
            ack_vld    <= ack_req && sv_en_q && irr_any;
            ack_vector <= deliverable ? irr_top : sv_vec_q;
        end
    end

    // End-of-interrupt broadcast for retired level-triggered vectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_bc_valid  <= 1'b0;
            eoi_bc_vector <= '0;
        end else begin
            eoi_bc_valid  <= eoi_take && tmr_q[isr_top] && !sv_dir_q;
            eoi_bc_vector <= isr_top;
        end
    end

    assign irq_pending = sv_en_q && deliverable;
endmodule

// File: rtl/vpu_accept_unit_chk.sv
// Module: vpu_accept_unit_chk
// Cycle-by-cycle protocol and priority checks, bound to vpu_accept_unit.
module vpu_accept_unit_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_req,
    input logic             ack_done,
    input logic             ack_vld,
    input logic             eoi_strobe,
    input logic             eoi_bc_valid,
    input logic             irq_pending,
    input logic [VEC_W-1:0] ppr_out,
    input logic [VEC_W-1:0] tpr_q,
    input logic             sv_en_q,
    input logic             isr_any
);
    AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_done);                                         // R12
    AST_ACK_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |=> !ack_done);                                       // R12
    AST_VLD_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> ack_done);                                         // R8
    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !sv_en_q |-> !irq_pending);                                    // R11
    AST_OFF_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !sv_en_q) |=> !ack_vld);                           // R11
    AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ppr_out[VEC_W-1:VEC_W-4] >= tpr_q[VEC_W-1:VEC_W-4]);           // R4
    AST_PPR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !isr_any |-> (ppr_out == tpr_q));                              // R4
    AST_BC_AFTER_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bc_valid |-> $past(eoi_strobe));                           // R9
    AST_EMPTY_EOI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_strobe && !isr_any) |=> !eoi_bc_valid);                   // R10
endmodule

bind vpu_accept_unit vpu_accept_unit_chk #(.VEC_W(vpu_pkg::VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_done(ack_done),
    .ack_vld(ack_vld), .eoi_strobe(eoi_strobe), .eoi_bc_valid(eoi_bc_valid),
    .irq_pending(irq_pending), .ppr_out(ppr_out), .tpr_q(tpr_q),
    .sv_en_q(sv_en_q), .isr_any(isr_any)
);

// File: tb/vpu_accept_unit_tb.sv
`timescale 1ns/1ps
// Bench: table of operations with expected outputs, then directed reset tests.
module vpu_accept_unit_tb;
    localparam logic [2:0] OP_SVR = 3'd0, OP_TPR = 3'd1, OP_SETE = 3'd2,
                           OP_SETL = 3'd3, OP_ACK = 3'd4, OP_EOI = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] arg;
        logic        pend;
        logic [7:0]  ppr;
        logic        ov;
        logic [7:0]  ovec;
        logic [7:0]  req;
    } ent_t;

    localparam int N_ENT = 43;
    localparam ent_t TBL [N_ENT] = '{
        '{OP_SVR,  16'h01F0, 1'b0, 8'h00, 1'b0, 8'h00, 8'd11}, // R11 enable on
        '{OP_SETE, 16'h0021, 1'b1, 8'h00, 1'b0, 8'h00, 8'd5},  // R5
        '{OP_SETL, 16'h0085, 1'b1, 8'h00, 1'b0, 8'h00, 8'd2},  // R2
        '{OP_SETE, 16'h0047, 1'b1, 8'h00, 1'b0, 8'h00, 8'd3},  // R3
        '{OP_ACK,  16'h0000, 1'b0, 8'h80, 1'b1, 8'h85, 8'd3},  // R3 highest first
        '{OP_ACK,  16'h0000, 1'b0, 8'h80, 1'b1, 8'hF0, 8'd7},  // R7 spurious
        '{OP_SETE, 16'h009A, 1'b1, 8'h80, 1'b0, 8'h00, 8'd5},  // R5 class above
        '{OP_ACK,  16'h0000, 1'b0, 8'h90, 1'b1, 8'h9A, 8'd6},  // R6 nested
        '{OP_EOI,  16'h0000, 1'b0, 8'h80, 1'b0, 8'h00, 8'd9},  // R9 edge, no bc
        '{OP_EOI,  16'h0000, 1'b1, 8'h00, 1'b1, 8'h85, 8'd9},  // R9 level bc
        '{OP_TPR,  16'h0045, 1'b0, 8'h45, 1'b0, 8'h00, 8'd5},  // R5 equal class blocks
        '{OP_TPR,  16'h003C, 1'b1, 8'h3C, 1'b0, 8'h00, 8'd5},  // R5
        '{OP_ACK,  16'h0000, 1'b0, 8'h40, 1'b1, 8'h47, 8'd4},  // R4 isr class wins
        '{OP_TPR,  16'h005A, 1'b0, 8'h5A, 1'b0, 8'h00, 8'd4},  // R4 tpr wins
        '{OP_TPR,  16'h0000, 1'b0, 8'h40, 1'b0, 8'h00, 8'd4},  // R4
        '{OP_EOI,  16'h0000, 1'b1, 8'h00, 1'b0, 8'h00, 8'd9},  // R9
        '{OP_ACK,  16'h0000, 1'b0, 8'h20, 1'b1, 8'h21, 8'd6},  // R6
        '{OP_EOI,  16'h0000, 1'b0, 8'h00, 1'b0, 8'h00, 8'd9},  // R9
        '{OP_EOI,  16'h0000, 1'b0, 8'h00, 1'b0, 8'h00, 8'd10}, // R10 empty
        '{OP_ACK,  16'h0000, 1'b0, 8'h00, 1'b0, 8'h00, 8'd8},  // R8 nothing
        '{OP_SVR,  16'h11F0, 1'b0, 8'h00, 1'b0, 8'h00, 8'd11}, // R11 directed on
        '{OP_SETL, 16'h0033, 1'b1, 8'h00, 1'b0, 8'h00, 8'd2},  // R2
        '{OP_ACK,  16'h0000, 1'b0, 8'h30, 1'b1, 8'h33, 8'd6},  // R6
        '{OP_EOI,  16'h0000, 1'b0, 8'h00, 1'b0, 8'h00, 8'd9},  // R9 directed: no bc
        '{OP_SETE, 16'h0050, 1'b1, 8'h00, 1'b0, 8'h00, 8'd5},  // R5
        '{OP_SVR,  16'h00F0, 1'b0, 8'h00, 1'b0, 8'h00, 8'd11}, // R11 enable off
        '{OP_ACK,  16'h0000, 1'b0, 8'h00, 1'b0, 8'h00, 8'd11}, // R11 no vector
        '{OP_SVR,  16'h0105, 1'b1, 8'h00, 1'b0, 8'h00, 8'd11}, // R11 request kept
        '{OP_TPR,  16'h0070, 1'b0, 8'h70, 1'b0, 8'h00, 8'd5},  // R5
        '{OP_ACK,  16'h0000, 1'b0, 8'h70, 1'b1, 8'h05, 8'd7},  // R7 new spurious
        '{OP_TPR,  16'h0000, 1'b1, 8'h00, 1'b0, 8'h00, 8'd5},  // R5
        '{OP_SETL, 16'h00FF, 1'b1, 8'h00, 1'b0, 8'h00, 8'd2},  // R2
        '{OP_ACK,  16'h0000, 1'b0, 8'hF0, 1'b1, 8'hFF, 8'd3},  // R3 top vector
        '{OP_EOI,  16'h0000, 1'b1, 8'h00, 1'b1, 8'hFF, 8'd9},  // R9
        '{OP_ACK,  16'h0000, 1'b0, 8'h50, 1'b1, 8'h50, 8'd6},  // R6
        '{OP_EOI,  16'h0000, 1'b0, 8'h00, 1'b0, 8'h00, 8'd9},  // R9
        '{OP_SETE, 16'h0003, 1'b1, 8'h00, 1'b0, 8'h00, 8'd5},  // R5 ppr zero passes
        '{OP_ACK,  16'h0000, 1'b0, 8'h00, 1'b1, 8'h03, 8'd5},  // R5
        '{OP_EOI,  16'h0000, 1'b0, 8'h00, 1'b0, 8'h00, 8'd9},  // R9
        '{OP_SETL, 16'h0066, 1'b1, 8'h00, 1'b0, 8'h00, 8'd2},  // R2
        '{OP_SETE, 16'h0066, 1'b1, 8'h00, 1'b0, 8'h00, 8'd2},  // R2 overwrite
        '{OP_ACK,  16'h0000, 1'b0, 8'h60, 1'b1, 8'h66, 8'd6},  // R6
        '{OP_EOI,  16'h0000, 1'b0, 8'h00, 1'b0, 8'h00, 8'd2}   // R2 now edge
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_level, ack_req, eoi_strobe, tpr_we, svr_we;
    logic [7:0]  req_vector, tpr_wdata;
    logic [15:0] svr_wdata;
    logic        ack_done, ack_vld, eoi_bc_valid, irq_pending;
    logic [7:0]  ack_vector, eoi_bc_vector, ppr_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    vpu_accept_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
        .ack_req(ack_req), .ack_done(ack_done), .ack_vld(ack_vld),
        .ack_vector(ack_vector), .eoi_strobe(eoi_strobe),
        .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vector(eoi_bc_vector),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .svr_we(svr_we),
        .svr_wdata(svr_wdata), .ppr_out(ppr_out), .irq_pending(irq_pending)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                       input int req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_level = 0; req_vector = 0; ack_req = 0;
        eoi_strobe = 0; tpr_we = 0; tpr_wdata = 0; svr_we = 0; svr_wdata = 0;
    endtask

    // Drive one operation for one edge; return at the following negedge.
    task automatic run_op(input logic [2:0] op, input logic [15:0] arg);
        case (op)
            OP_SVR:  begin svr_we = 1; svr_wdata = arg; end
            OP_TPR:  begin tpr_we = 1; tpr_wdata = arg[7:0]; end
            OP_SETE: begin req_valid = 1; req_vector = arg[7:0]; req_level = 0; end
            OP_SETL: begin req_valid = 1; req_vector = arg[7:0]; req_level = 1; end
            OP_ACK:  ack_req = 1;
            OP_EOI:  eoi_strobe = 1;
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(16'(ppr_out), 16'h00, 1, "reset ppr");
        chk(16'(irq_pending), 16'h0, 1, "reset pending");
        chk(16'(ack_done), 16'h0, 12, "reset ack_done");
        chk(16'(eoi_bc_valid), 16'h0, 1, "reset broadcast");
        run_op(OP_SETE, 16'h0090);
        chk(16'(irq_pending), 16'h0, 1, "enable off after reset");
        run_op(OP_ACK, 16'h0);
        chk(16'(ack_vld), 16'h0, 11, "ack with enable off");
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);

        for (int i = 0; i < N_ENT; i++) begin
            ent_t e;
            e = TBL[i];
            run_op(e.op, e.arg);
            chk(16'(irq_pending), 16'(e.pend), e.req, $sformatf("step %0d pending", i));
            chk(16'(ppr_out), 16'(e.ppr), e.req, $sformatf("step %0d ppr", i));
            chk(16'(ack_done), 16'(e.op == OP_ACK), 12, $sformatf("step %0d ack_done", i));
            if (e.op == OP_ACK) begin
                chk(16'(ack_vld), 16'(e.ov), e.req, $sformatf("step %0d ack_vld", i));
                if (e.ov)
                    chk(16'(ack_vector), 16'(e.ovec), e.req, $sformatf("step %0d ack_vector", i));
            end
            if (e.op == OP_EOI) begin
                chk(16'(eoi_bc_valid), 16'(e.ov), e.req, $sformatf("step %0d bc_valid", i));
                if (e.ov)
                    chk(16'(eoi_bc_vector), 16'(e.ovec), e.req, $sformatf("step %0d bc_vector", i));
            end else begin
                chk(16'(eoi_bc_valid), 16'h0, 9, $sformatf("step %0d stray broadcast", i));
            end
        end

        // R1: reset in the middle of service clears all sets and priority
        run_op(OP_SVR, 16'h01F0);
        run_op(OP_TPR, 16'h0020);
        run_op(OP_SETL, 16'h0090);
        run_op(OP_ACK, 16'h0);
        chk(16'(ack_vector), 16'h90, 6, "pre-reset ack");
        run_op(OP_SETE, 16'h00A4);
        rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
        chk(16'(ppr_out), 16'h00, 1, "ppr after mid reset");
        chk(16'(irq_pending), 16'h0, 1, "pending after mid reset");
        run_op(OP_EOI, 16'h0);
        chk(16'(eoi_bc_valid), 16'h0, 1, "in-service cleared by reset");
        run_op(OP_SVR, 16'h01F0);
        chk(16'(irq_pending), 16'h0, 1, "requests cleared by reset");
        run_op(OP_ACK, 16'h0);
        chk(16'(ack_vld), 16'h0, 1, "no vector after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule